// File: doc/BRIEF.md
# Prescaled Dual-Compare Timer

This block is an 8-bit up-counter with a built-in clock divider and two compare channels. A 3-bit select field either halts counting or picks one of seven division ratios of the system clock: 1, 8, 32, 64, 128, 256 or 1024. The divider produces a one-cycle tick enable, and the counter advances by one on each tick.

Each compare channel holds an 8-bit value. On every tick the channel compares that value with the counter value as it stands before the increment. When they are equal, the channel sets a sticky flag. If the channel's toggle enable is on, it also inverts its waveform pin. A sticky overflow flag records the wrap from 255 to 0.

Software reaches the control, counter, compare and flag registers through a plain single-cycle register port: a write strobe with an address and data, and a read path that answers in the same cycle. A software write to the counter masks any compare hit on the first tick after the write. This keeps a freshly loaded value from firing at once. A hit that is skipped over because the counter was rewritten is not recovered. The register port is control-only and has no back-pressure: each write strobe is taken in the cycle it is asserted, and a read result is valid while its address is held.

Top module: `tick_timer`

## Requirements
- R1: Control register (address 0) bits [2:0] select the rate: code 0 halts the counter and holds the divider at zero; codes 1 to 7 give a tick every 1, 8, 32, 64, 128, 256 and 1024 clocks respectively, with the divider starting from zero when leaving code 0.
- R2: The counter (address 1) is 8 bits, resets to 0, is readable and writable, advances by one per tick and wraps from 255 to 0.
- R3: Compare value A (address 2) and compare value B (address 3) are 8-bit read/write registers that reset to 0.
- R4: At a tick where the counter (pre-increment) equals a compare value, that channel's flag is set: flag bit 0 for A, bit 1 for B.
- R5: Control bit 3 (channel A) and bit 4 (channel B) enable toggling: a hit on an enabled channel inverts its waveform output; otherwise the output holds its value. Both outputs reset to 0.
- R6: After a software write to the counter, a compare hit on the first following tick is suppressed on both channels.
- R7: A tick that wraps the counter from 255 to 0 sets the overflow flag, bit 2.
- R8: Flags (address 4) are sticky and mirrored on `flag_o`; writing 1 to a bit clears it, writing 0 leaves it; a set event in the same cycle as its clear wins.
- R9: A counter write in the same cycle as a tick loads the written value, with no increment.
- R10: All registers read back in the same cycle through `reg_rdata`; control reads as its 5 bits zero-extended, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |
| flag_o | output | 3 | Sticky flags: {overflow, hit B, hit A} |

## Verification
A divider that is out of phase moves every later tick. This shows up as a wrong counter readback and as hits that come early or late, within one selected period. A stale suppression bit either swallows a hit or lets one through, which shows on `flag_o` and the waveform pins on the clock after the tick concerned. A wrong flag or toggle state appears at the pins one clock after the event. The bench therefore compares the pins with a behavioural model on every clock and compares register reads at chosen moments.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 10;
  localparam int SEL_W = 3;
  localparam int CH_N  = 2;

  typedef enum logic [2:0] {
    ADR_CTL  = 3'd0,
    ADR_CNT  = 3'd1,
    ADR_CMPA = 3'd2,
    ADR_CMPB = 3'd3,
    ADR_FLG  = 3'd4
  } reg_adr_e;

  localparam int CTL_W     = SEL_W + CH_N;
  localparam int TEN_LSB   = SEL_W;
  localparam int FLG_W     = CH_N + 1;
  localparam int FLG_OVF   = CH_N;

  // low-bit mask the divider must fill before a tick, per select code
  function automatic logic [PRE_W-1:0] sel_mask(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    sel_mask = PRE_W'(7);
      3'd3:    sel_mask = PRE_W'(31);
      3'd4:    sel_mask = PRE_W'(63);
      3'd5:    sel_mask = PRE_W'(127);
      3'd6:    sel_mask = PRE_W'(255);
      3'd7:    sel_mask = PRE_W'(1023);
      default: sel_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [W-1:0] div_q;
  logic [W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (sel == '0)  div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  assign mask = W'(sel_mask(sel));
  assign tick = (sel != '0) && ((div_q & mask) == mask);

  AST_HALT_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> (div_q == '0)) else $error("divider not held"); // R1
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !tick) else $error("tick while halted"); // R1
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         blocked,
  output logic         ovf_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // masks the compare on the first tick after a software load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     blocked <= 1'b0;
    else if (wr_en) blocked <= 1'b1;
    else if (tick)  blocked <= 1'b0;
  end

  assign ovf_evt = tick && !wr_en && (cnt == '1);

  AST_WR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_data))) else $error("write lost"); // R9
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (cnt == $past(cnt) + 1'b1)) else $error("bad step"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt)) else $error("count drift"); // R1
  AST_BLOCK_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> !blocked) else $error("mask outlived tick"); // R6
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         blocked,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         tog_en,
  output logic         hit,
  output logic         wave
);
  assign hit = tick && !blocked && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wave <= 1'b0;
    else if (hit && tog_en) wave <= ~wave;
  end

  AST_WAVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && tog_en) |=> (wave != $past(wave))) else $error("no toggle"); // R5
  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && tog_en) |=> $stable(wave)) else $error("spurious toggle"); // R5
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wave_a,
  output logic       wave_b,
  output logic [2:0] flag_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cmp_q [CH_N];
  logic [FLG_W-1:0] flg_q;
  logic             tick, blocked, ovf_evt;
  logic [CNT_W-1:0] cnt;
  logic [CH_N-1:0]  hit, wave;
  logic [FLG_W-1:0] set_vec, clr_vec;
  logic             wr_cnt, wr_flg;

  assign wr_cnt = reg_wr && (reg_addr == ADR_CNT);
  assign wr_flg = reg_wr && (reg_addr == ADR_FLG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      for (int i = 0; i < CH_N; i++) cmp_q[i] <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_CTL:  ctl_q    <= reg_wdata[CTL_W-1:0];
        ADR_CMPA: cmp_q[0] <= reg_wdata;
        ADR_CMPB: cmp_q[1] <= reg_wdata;
        default: ;
      endcase
    end
  end

  tmr_prescaler #(.W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sel(ctl_q[SEL_W-1:0]), .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_cnt),
    .wr_data(reg_wdata), .cnt(cnt), .blocked(blocked), .ovf_evt(ovf_evt)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    tmr_compare #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .blocked(blocked),
      .cnt(cnt), .cmp(cmp_q[c]), .tog_en(ctl_q[TEN_LSB+c]),
      .hit(hit[c]), .wave(wave[c])
    );
  end

  assign set_vec = {ovf_evt, hit};
  assign clr_vec = wr_flg ? reg_wdata[FLG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    case (reg_addr)
      ADR_CTL:  reg_rdata = 8'(ctl_q);
      ADR_CNT:  reg_rdata = cnt;
      ADR_CMPA: reg_rdata = cmp_q[0];
      ADR_CMPB: reg_rdata = cmp_q[1];
      ADR_FLG:  reg_rdata = 8'(flg_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign wave_a = wave[0];
  assign wave_b = wave[1];
  assign flag_o = flg_q;

  AST_MASKED_TICK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blocked) |-> (hit == '0)) else $error("hit after load"); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flg_q & $past(set_vec)) == $past(set_vec))) else $error("set lost"); // R8
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flg |=> ((flg_q & $past(flg_q)) == $past(flg_q))) else $error("flag dropped"); // R8
  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt == '1) |=> flg_q[FLG_OVF]) else $error("wrap unflagged"); // R7
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] rdata;
  logic       wa, wb;
  logic [2:0] fl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(bus_wr), .reg_addr(bus_addr),
    .reg_wdata(bus_wdata), .reg_rdata(rdata), .wave_a(wa), .wave_b(wb),
    .flag_o(fl)
  );

  // behavioural reference
  int m_pre, m_cnt, m_blk, m_ctl, m_ca, m_cb, m_flg, m_wa, m_wb;
  int t_sel, t_rat, t_clr;
  bit t_tk, t_cw, t_ha, t_hb, t_ov;

  function automatic int ratio_of(input int s);
    case (s)
      1: return 1;    2: return 8;    3: return 32;  4: return 64;
      5: return 128;  6: return 256;  7: return 1024;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      0: return m_ctl;  1: return m_cnt;  2: return m_ca;
      3: return m_cb;   4: return m_flg;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_blk = 0; m_ctl = 0; m_ca = 0; m_cb = 0;
      m_flg = 0; m_wa = 0; m_wb = 0;
    end else begin
      t_sel = m_ctl & 7;
      t_rat = ratio_of(t_sel);
      t_tk  = (t_sel != 0) && ((m_pre % t_rat) == t_rat - 1);
      t_cw  = bus_wr && bus_addr == 3'd1;
      t_ha  = t_tk && (m_blk == 0) && (m_cnt == m_ca);
      t_hb  = t_tk && (m_blk == 0) && (m_cnt == m_cb);
      t_ov  = t_tk && !t_cw && (m_cnt == 255);
      t_clr = (bus_wr && bus_addr == 3'd4) ? (bus_wdata & 7) : 0;
      m_pre = (t_sel == 0) ? 0 : (m_pre + 1) % 1024;
      if (t_cw) m_blk = 1; else if (t_tk) m_blk = 0;
      if (t_cw) m_cnt = bus_wdata; else if (t_tk) m_cnt = (m_cnt + 1) % 256;
      m_flg = (m_flg & ~t_clr & 7) | int'(t_ha) | (int'(t_hb) << 1) | (int'(t_ov) << 2);
      if (t_ha && ((m_ctl >> 3) & 1) == 1) m_wa = m_wa ^ 1;
      if (t_hb && ((m_ctl >> 4) & 1) == 1) m_wb = m_wb ^ 1;
      if (bus_wr && bus_addr == 3'd0) m_ctl = bus_wdata & 31;
      if (bus_wr && bus_addr == 3'd2) m_ca = bus_wdata;
      if (bus_wr && bus_addr == 3'd3) m_cb = bus_wdata;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of registered pins
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 wave_a", int'(wa), m_wa);
      chk("R5 wave_b", int'(wb), m_wb);
      chk("R8 flag_o", int'(fl), m_flg);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int a, output int v);
    @(negedge clk);
    bus_addr = 3'(a);
    #1;
    v = int'(rdata);
    chk(req, v, exp_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset values and unused addresses
    for (int a = 0; a < 8; a++) begin
      rd("R10 reset read", a, v);
      chk("R2 R3 reset zero", v, 0);
    end

    // basic counting, hits, toggles
    wr(2, 5); wr(3, 200);
    wr(0, 1 | 8 | 16);
    idle(20);
    rd("R2 count", 1, v);
    rd("R4 hit A flag", 4, v);
    chk("R4 flag A set", v & 1, 1);
    idle(300);
    rd("R7 wrap", 4, v);
    chk("R7 overflow set", (v >> 2) & 1, 1);
    chk("R4 flag B set", (v >> 1) & 1, 1);

    // write-1 clear
    wr(4, 7);
    rd("R8 clear", 4, v);
    chk("R8 cleared", v, 0);

    // load suppression
    wr(2, 40);
    wr(1, 40);
    idle(3);
    rd("R6 masked", 4, v);
    chk("R6 no hit after load", v & 1, 0);

    // set beats same-cycle clear
    wr(4, 7);
    wr(1, 39);
    wr(4, 1);
    rd("R8 set wins", 4, v);
    chk("R8 set over clear", v & 1, 1);

    // write beats tick
    wr(1, 100);
    rd("R9 load", 1, v);
    chk("R9 loaded then one tick", v, 101);

    // halt
    wr(0, 0);
    rd("R1 halt", 1, held);
    idle(50);
    rd("R1 halt hold", 1, v);
    chk("R1 halted", v, held);

    // every divided rate
    for (int s = 2; s < 8; s++) begin
      wr(0, 0);
      wr(1, 0);
      wr(0, s | 8);
      idle(3 * ratio_of(s) + 5);
      rd("R1 rate", 1, v);
      chk("R1 rate ticks", v, 3);
      rd("R10 ctl read", 0, v);
    end

    // toggles off, compare B near count
    wr(0, 1);
    wr(3, 30); wr(1, 20);
    idle(40);
    rd("R3 cmp B", 3, v);
    rd("R5 no toggle", 4, v);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule